// File: doc/BRIEF.md
# Miss Status Holding Register Queue

This block keeps the bookkeeping for cache misses that are still outstanding. Each live slot records a block address, a secure flag, an uncacheable flag, the time at which the miss may be sent downstream, whether it has already been sent (in service), and how many requesters are waiting on it. The cache drives one command per cycle on a single operation port. The commands are: allocate a slot for a new miss, send a slot (mark it in service), return a sent slot to waiting, move a waiting slot to the front, pop one waiting requester, and release a slot.

The queue keeps a dispatch list of the waiting slots, and the head of that list is the next miss to send. Two lookups are combinational and are answered from the current state. The first is an address match over every live cacheable slot. The second is a pending match over the waiting slots only. The block also reports its fill level, a one-cycle overflow error, a one-cycle pulse when a popped requester frees the queue from its full level, and a drain-complete pulse for power or reset sequencing.

With `NUM_ENTRIES` configured slots and `RESERVE` reserve slots, the queue holds `NUM_ENTRIES + RESERVE - 1` physical slots. It reports full early, so that `RESERVE` slots stay available for misses that the cache cannot refuse.

Top module: `mshr_queue`

## Requirements
- R1: The physical slot count is PHYS = NUM_ENTRIES + RESERVE - 1. `full` is high while allocCount >= PHYS - RESERVE. `empty` is high while allocCount is 0. After reset both counts are 0.
- R2: Allocate (opCode 1) takes the slot shown on `allocSlot`, which is the top of a last-in-first-out free pool. A released slot goes back on top of the pool. After reset the pool hands out slots 0, 1, 2, ... in ascending order.
- R3: `matchHit`/`matchSlot` report the lowest-numbered live slot whose address and secure flag both equal the lookup inputs. Slots marked uncacheable are never reported. In-service slots are reported.
- R4: `pendHit`/`pendSlot` report the lowest-numbered waiting (not in-service) slot whose address and secure flag equal the lookup inputs. The uncacheable flag does not exclude a slot here. In-service slots are never reported.
- R5: A slot entering the dispatch list with ready time T is appended if the list is empty or its last slot's time is <= T. Otherwise it goes in front of the first slot whose time is > T, so equal times keep arrival order. `headSlot` is the first slot of the list.
- R6: Issue (opCode 2) on a live waiting slot with opDone = 0 removes it from the dispatch list and increments svcCount. With opDone = 1 the slot is released instead.
- R7: Return-to-waiting (opCode 3) on an in-service slot clears its in-service state, decrements svcCount, and re-inserts the slot by its stored ready time under the R5 rule.
- R8: Move-to-front (opCode 4) puts a live waiting slot at the head of the dispatch list. It has no effect on an in-service slot.
- R9: Release (opCode 6) of a live slot decrements allocCount. If the slot was in service, svcCount is also decremented; otherwise the slot leaves the dispatch list.
- R10: Pop (opCode 5) on a live slot with a nonzero target count decrements that count. When the count reaches zero the slot is released as in R9. `popUnfull` pulses for one cycle when that release takes the queue from full to not full.
- R11: While `drainReq` is high, `drainDone` pulses for one cycle in the cycle after allocCount becomes 0. If drainReq rises while allocCount is already 0, `drainDone` pulses in the next cycle.
- R12: Allocate while all PHYS slots are live leaves all state unchanged and pulses `allocErr` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Command strobe |
| opCode | input | 3 | 1 alloc, 2 issue, 3 return-to-waiting, 4 front, 5 pop, 6 release |
| opSlot | input | IDX_W | Target slot for all commands except allocate |
| opAddr | input | ADDR_W | Block address for allocate |
| opSecure | input | 1 | Secure flag for allocate |
| opUncache | input | 1 | Uncacheable flag for allocate |
| opReady | input | TIME_W | Ready time for allocate |
| opTargets | input | TGT_W | Initial target count for allocate |
| opDone | input | 1 | Issue completes the slot |
| drainReq | input | 1 | Drain request level |
| lookAddr | input | ADDR_W | Lookup block address |
| lookSecure | input | 1 | Lookup secure flag |
| allocSlot | output | IDX_W | Slot the next allocate will take |
| matchHit | output | 1 | Address match found |
| matchSlot | output | IDX_W | Matching slot |
| pendHit | output | 1 | Waiting match found |
| pendSlot | output | IDX_W | Waiting matching slot |
| headValid | output | 1 | Dispatch list not empty |
| headSlot | output | IDX_W | Next slot to send |
| allocCount | output | CNT_W | Live slot count |
| svcCount | output | CNT_W | In-service slot count |
| full | output | 1 | Fill level reached |
| empty | output | 1 | No live slot |
| allocErr | output | 1 | Overflow allocate pulse |
| popUnfull | output | 1 | Pop released the full condition |
| drainDone | output | 1 | Drain complete pulse |

## Verification
A corrupted dispatch list shows on `headSlot` in the cycle after the command that damaged it. It may show as a stale slot, a sent slot still at the head, or a misplaced tie. A wrong free pool shows on `allocSlot` before the next allocate takes it. Counter drift between live and in-service slots is visible at once on `allocCount`, `svcCount` and `full`. It also appears later as a missing or early `drainDone` or `popUnfull` pulse. Lookup errors show combinationally in the same cycle the lookup inputs change.

// File: rtl/mshrq_pkg.sv
package mshrq_pkg;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_ALLOC  = 3'd1,
    OP_ISSUE  = 3'd2,
    OP_REPEND = 3'd3,
    OP_FRONT  = 3'd4,
    OP_POP    = 3'd5,
    OP_FREE   = 3'd6
  } opcode_e;

  // Strobes from control to datapath; at most one command per cycle.
  typedef struct packed {
    logic alloc;
    logic issue;
    logic repend;
    logic front;
    logic pop;
    logic free;
  } strobe_t;

endpackage

// File: rtl/mshrq_ctrl.sv
module mshrq_ctrl
  import mshrq_pkg::*;
#(
  parameter int PHYS    = 5,
  parameter int FULL_AT = 3,
  parameter int TGT_W   = 3,
  parameter int CNT_W   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [2:0]       opCode,
  input  logic             opDone,
  input  logic             selVld,
  input  logic             selInsvc,
  input  logic [TGT_W-1:0] selTgt,
  input  logic             drainReq,
  output strobe_t          stb,
  output logic [CNT_W-1:0] allocCnt,
  output logic [CNT_W-1:0] svcCnt,
  output logic             full,
  output logic             empty,
  output logic             allocErr,
  output logic             popUnfull,
  output logic             drainDone
);

  logic isAlloc, isIssue, isRepend, isFront, isPop, isFree;
  logic popFree, issueFree;
  logic [CNT_W-1:0] allocN, svcN;
  logic drainQ;

  assign isAlloc  = opValid && (opCode == OP_ALLOC);
  assign isIssue  = opValid && (opCode == OP_ISSUE);
  assign isRepend = opValid && (opCode == OP_REPEND);
  assign isFront  = opValid && (opCode == OP_FRONT);
  assign isPop    = opValid && (opCode == OP_POP);
  assign isFree   = opValid && (opCode == OP_FREE);

  assign issueFree = isIssue && selVld && !selInsvc && opDone;
  assign popFree   = isPop && selVld && (selTgt == TGT_W'(1));

  always_comb begin
    stb        = '0;
    stb.alloc  = isAlloc && (allocCnt < CNT_W'(PHYS));
    stb.issue  = isIssue && selVld && !selInsvc && !opDone;
    stb.repend = isRepend && selVld && selInsvc;
    stb.front  = isFront && selVld && !selInsvc;
    stb.pop    = isPop && selVld && (selTgt != '0);
    stb.free   = (isFree && selVld) || issueFree || popFree;
  end

  always_comb begin
    allocN = allocCnt;
    if (stb.alloc) allocN = allocN + CNT_W'(1);
    if (stb.free)  allocN = allocN - CNT_W'(1);
    svcN = svcCnt;
    if (stb.issue) svcN = svcN + CNT_W'(1);
    if (stb.repend || (stb.free && selInsvc)) svcN = svcN - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      allocCnt  <= '0;
      svcCnt    <= '0;
      allocErr  <= 1'b0;
      popUnfull <= 1'b0;
      drainDone <= 1'b0;
      drainQ    <= 1'b0;
    end else begin
      allocCnt  <= allocN;
      svcCnt    <= svcN;
      allocErr  <= isAlloc && (allocCnt == CNT_W'(PHYS));
      popUnfull <= popFree && full && (allocN < CNT_W'(FULL_AT));
      drainDone <= drainReq && (allocN == '0) && ((allocCnt != '0) || !drainQ);
      drainQ    <= drainReq;
    end
  end

  assign full  = (allocCnt >= CNT_W'(FULL_AT));
  assign empty = (allocCnt == '0);

  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    allocCnt <= CNT_W'(PHYS));

  p_svc_le_alloc_r6: assert property (@(posedge clk) disable iff (!rstN)
    svcCnt <= allocCnt);

  p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rstN)
    (isAlloc && allocCnt == CNT_W'(PHYS)) |=> $stable(allocCnt));

  p_drain_empty_r11: assert property (@(posedge clk) disable iff (!rstN)
    drainDone |-> empty);

endmodule

// File: rtl/mshrq_dp.sv
module mshrq_dp
  import mshrq_pkg::*;
#(
  parameter int PHYS   = 5,
  parameter int IDX_W  = 3,
  parameter int CNT_W  = 3,
  parameter int ADDR_W = 8,
  parameter int TIME_W = 8,
  parameter int TGT_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [IDX_W-1:0]  opSlot,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic              opSecure,
  input  logic              opUncache,
  input  logic [TIME_W-1:0] opReady,
  input  logic [TGT_W-1:0]  opTargets,
  input  logic [ADDR_W-1:0] lookAddr,
  input  logic              lookSecure,
  output logic [IDX_W-1:0]  allocSlot,
  output logic              selVld,
  output logic              selInsvc,
  output logic [TGT_W-1:0]  selTgt,
  output logic              matchHit,
  output logic [IDX_W-1:0]  matchSlot,
  output logic              pendHit,
  output logic [IDX_W-1:0]  pendSlot,
  output logic              headValid,
  output logic [IDX_W-1:0]  headSlot
);

  // Slot state
  logic [PHYS-1:0]   vld, sec, unc, insvc;
  logic [ADDR_W-1:0] addr [PHYS];
  logic [TIME_W-1:0] rdy  [PHYS];
  logic [TGT_W-1:0]  tgt  [PHYS];

  // Free pool (stack) and dispatch list
  logic [IDX_W-1:0] stk [PHYS];
  logic [CNT_W-1:0] stkCnt;
  logic [IDX_W-1:0] ord [PHYS];
  logic [CNT_W-1:0] ordCnt;

  // Next-state of the dispatch list
  logic [IDX_W-1:0]  ordA [PHYS];
  logic [IDX_W-1:0]  ordB [PHYS];
  logic [CNT_W-1:0]  cntA, cntB, pos;
  logic              remOn, insOn, insFront, shiftHit, found;
  logic [IDX_W-1:0]  insSlot;
  logic [TIME_W-1:0] insKey;

  assign allocSlot = (stkCnt == '0) ? stk[0] : stk[IDX_W'(stkCnt - CNT_W'(1))];
  assign selVld    = vld[opSlot];
  assign selInsvc  = insvc[opSlot];
  assign selTgt    = tgt[opSlot];
  assign headValid = (ordCnt != '0);
  assign headSlot  = ord[0];

  assign remOn    = stb.issue || stb.front || (stb.free && !insvc[opSlot]);
  assign insOn    = stb.alloc || stb.repend || stb.front;
  assign insFront = stb.front;
  assign insSlot  = stb.alloc ? allocSlot : opSlot;
  assign insKey   = stb.alloc ? opReady : rdy[opSlot];

  always_comb begin
    ordA     = ord;
    cntA     = ordCnt;
    shiftHit = 1'b0;
    if (remOn) begin
      for (int i = 0; i < PHYS - 1; i++) begin
        if (ord[i] == opSlot && CNT_W'(i) < ordCnt) shiftHit = 1'b1;
        if (shiftHit) ordA[i] = ord[i+1];
      end
      cntA = ordCnt - CNT_W'(1);
    end

    pos   = cntA;
    found = 1'b0;
    for (int i = 0; i < PHYS; i++) begin
      if (!found && CNT_W'(i) < cntA && rdy[ordA[i]] > insKey) begin
        pos   = CNT_W'(i);
        found = 1'b1;
      end
    end
    if (cntA != '0 && rdy[ordA[IDX_W'(cntA - CNT_W'(1))]] <= insKey) pos = cntA;
    if (insFront) pos = '0;

    ordB = ordA;
    cntB = cntA;
    if (insOn) begin
      for (int i = PHYS - 1; i > 0; i--) begin
        if (CNT_W'(i) > pos) ordB[i] = ordA[i-1];
      end
      ordB[IDX_W'(pos)] = insSlot;
      cntB = cntA + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vld    <= '0;
      sec    <= '0;
      unc    <= '0;
      insvc  <= '0;
      stkCnt <= CNT_W'(PHYS);
      ordCnt <= '0;
      for (int i = 0; i < PHYS; i++) begin
        addr[i] <= '0;
        rdy[i]  <= '0;
        tgt[i]  <= '0;
        stk[i]  <= IDX_W'(PHYS - 1 - i);
        ord[i]  <= IDX_W'(i);
      end
    end else begin
      ord    <= ordB;
      ordCnt <= cntB;
      if (stb.alloc) begin
        vld[allocSlot]   <= 1'b1;
        sec[allocSlot]   <= opSecure;
        unc[allocSlot]   <= opUncache;
        insvc[allocSlot] <= 1'b0;
        addr[allocSlot]  <= opAddr;
        rdy[allocSlot]   <= opReady;
        tgt[allocSlot]   <= opTargets;
        stkCnt           <= stkCnt - CNT_W'(1);
      end
      if (stb.issue)  insvc[opSlot] <= 1'b1;
      if (stb.repend) insvc[opSlot] <= 1'b0;
      if (stb.pop)    tgt[opSlot]   <= tgt[opSlot] - TGT_W'(1);
      if (stb.free) begin
        vld[opSlot]            <= 1'b0;
        insvc[opSlot]          <= 1'b0;
        stk[IDX_W'(stkCnt)]    <= opSlot;
        stkCnt                 <= stkCnt + CNT_W'(1);
      end
    end
  end

  always_comb begin
    matchHit  = 1'b0;
    matchSlot = '0;
    pendHit   = 1'b0;
    pendSlot  = '0;
    for (int i = PHYS - 1; i >= 0; i--) begin
      if (vld[i] && !unc[i] && addr[i] == lookAddr && sec[i] == lookSecure) begin
        matchHit  = 1'b1;
        matchSlot = IDX_W'(i);
      end
      if (vld[i] && !insvc[i] && addr[i] == lookAddr && sec[i] == lookSecure) begin
        pendHit  = 1'b1;
        pendSlot = IDX_W'(i);
      end
    end
  end

  p_head_waiting_r5: assert property (@(posedge clk) disable iff (!rstN)
    headValid |-> (vld[headSlot] && !insvc[headSlot]));

  p_pool_sum_r2: assert property (@(posedge clk) disable iff (!rstN)
    (32'(stkCnt) + 32'($countones(vld))) == PHYS);

  p_match_cacheable_r3: assert property (@(posedge clk) disable iff (!rstN)
    matchHit |-> (vld[matchSlot] && !unc[matchSlot]));

  p_pend_waiting_r4: assert property (@(posedge clk) disable iff (!rstN)
    pendHit |-> !insvc[pendSlot]);

endmodule

// File: rtl/mshr_queue.sv
module mshr_queue
  import mshrq_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int RESERVE     = 2,
  parameter int ADDR_W      = 8,
  parameter int TIME_W      = 8,
  parameter int TGT_W       = 3,
  // derived, keep at defaults
  parameter int PHYS        = NUM_ENTRIES + RESERVE - 1,
  parameter int IDX_W       = (PHYS > 1) ? $clog2(PHYS) : 1,
  parameter int CNT_W       = $clog2(PHYS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic [IDX_W-1:0]  opSlot,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic              opSecure,
  input  logic              opUncache,
  input  logic [TIME_W-1:0] opReady,
  input  logic [TGT_W-1:0]  opTargets,
  input  logic              opDone,
  input  logic              drainReq,
  input  logic [ADDR_W-1:0] lookAddr,
  input  logic              lookSecure,
  output logic [IDX_W-1:0]  allocSlot,
  output logic              matchHit,
  output logic [IDX_W-1:0]  matchSlot,
  output logic              pendHit,
  output logic [IDX_W-1:0]  pendSlot,
  output logic              headValid,
  output logic [IDX_W-1:0]  headSlot,
  output logic [CNT_W-1:0]  allocCount,
  output logic [CNT_W-1:0]  svcCount,
  output logic              full,
  output logic              empty,
  output logic              allocErr,
  output logic              popUnfull,
  output logic              drainDone
);

  localparam int FULL_AT = PHYS - RESERVE;

  strobe_t          stb;
  logic             selVld, selInsvc;
  logic [TGT_W-1:0] selTgt;

  mshrq_ctrl #(.PHYS(PHYS), .FULL_AT(FULL_AT), .TGT_W(TGT_W), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .opDone(opDone),
    .selVld(selVld), .selInsvc(selInsvc), .selTgt(selTgt), .drainReq(drainReq),
    .stb(stb), .allocCnt(allocCount), .svcCnt(svcCount), .full(full), .empty(empty),
    .allocErr(allocErr), .popUnfull(popUnfull), .drainDone(drainDone)
  );

  mshrq_dp #(.PHYS(PHYS), .IDX_W(IDX_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W),
             .TIME_W(TIME_W), .TGT_W(TGT_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .opSlot(opSlot), .opAddr(opAddr),
    .opSecure(opSecure), .opUncache(opUncache), .opReady(opReady),
    .opTargets(opTargets), .lookAddr(lookAddr), .lookSecure(lookSecure),
    .allocSlot(allocSlot), .selVld(selVld), .selInsvc(selInsvc), .selTgt(selTgt),
    .matchHit(matchHit), .matchSlot(matchSlot), .pendHit(pendHit),
    .pendSlot(pendSlot), .headValid(headValid), .headSlot(headSlot)
  );

endmodule

// File: tb/mshr_queue_test.sv
`timescale 1ns/1ps
module mshr_queue_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [2:0] opCode = '0;
  logic [2:0] opSlot = '0;
  logic [7:0] opAddr = '0;
  logic       opSecure = 1'b0;
  logic       opUncache = 1'b0;
  logic [7:0] opReady = '0;
  logic [2:0] opTargets = 3'd1;
  logic       opDone = 1'b0;
  logic       drainReq = 1'b0;
  logic [7:0] lookAddr = '0;
  logic       lookSecure = 1'b0;
  logic [2:0] allocSlot, matchSlot, pendSlot, headSlot, allocCount, svcCount;
  logic       matchHit, pendHit, headValid, full, empty, allocErr, popUnfull, drainDone;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  mshr_queue uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .opSlot(opSlot),
    .opAddr(opAddr), .opSecure(opSecure), .opUncache(opUncache), .opReady(opReady),
    .opTargets(opTargets), .opDone(opDone), .drainReq(drainReq), .lookAddr(lookAddr),
    .lookSecure(lookSecure), .allocSlot(allocSlot), .matchHit(matchHit),
    .matchSlot(matchSlot), .pendHit(pendHit), .pendSlot(pendSlot),
    .headValid(headValid), .headSlot(headSlot), .allocCount(allocCount),
    .svcCount(svcCount), .full(full), .empty(empty), .allocErr(allocErr),
    .popUnfull(popUnfull), .drainDone(drainDone)
  );

  typedef struct packed {
    logic [2:0] op;
    logic [2:0] slot;
    logic [7:0] addr;
    logic [7:0] rdy;
    logic [2:0] expHead;
    logic [2:0] expCnt;
    logic [2:0] expSvc;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{3'd1, 3'd0, 8'd10, 8'd50, 3'd0, 3'd1, 3'd0},  // R2 first slot 0
    '{3'd1, 3'd0, 8'd20, 8'd30, 3'd1, 3'd2, 3'd0},  // R5 earlier time goes first
    '{3'd1, 3'd0, 8'd30, 8'd30, 3'd1, 3'd3, 3'd0},  // R5 tie placed after slot 1
    '{3'd2, 3'd1, 8'd0,  8'd0,  3'd2, 3'd3, 3'd1},  // R6 issue slot 1
    '{3'd4, 3'd0, 8'd0,  8'd0,  3'd0, 3'd3, 3'd1},  // R8 slot 0 to front
    '{3'd3, 3'd1, 8'd0,  8'd0,  3'd0, 3'd3, 3'd0},  // R7 slot 1 back, appended
    '{3'd6, 3'd0, 8'd0,  8'd0,  3'd2, 3'd2, 3'd0},  // R9 release waiting slot 0
    '{3'd1, 3'd0, 8'd40, 8'd10, 3'd0, 3'd3, 3'd0}   // R2 slot 0 reused, R5 to head
  };

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doOp(input logic [2:0] code, input logic [2:0] slot,
                      input logic [7:0] a, input logic u, input logic [7:0] t,
                      input logic [2:0] ntg, input logic done);
    @(negedge clk);
    opValid = 1'b1; opCode = code; opSlot = slot; opAddr = a; opUncache = u;
    opReady = t; opTargets = ntg; opDone = done; opSecure = 1'b0;
    @(posedge clk);
    @(negedge clk);
    opValid = 1'b0; opCode = '0; opDone = 1'b0;
  endtask

  task automatic look(input logic [7:0] a, input logic s);
    lookAddr = a; lookSecure = s;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 / R2 reset state
    chk("R1 reset empty", empty, 1);
    chk("R1 reset full", full, 0);
    chk("R1 reset count", allocCount, 0);
    chk("R5 reset head valid", headValid, 0);
    chk("R2 reset alloc slot", allocSlot, 0);
    chk("R11 reset drainDone", drainDone, 0);

    for (int k = 0; k < 8; k++) begin
      doOp(TBL[k].op, TBL[k].slot, TBL[k].addr, 1'b0, TBL[k].rdy, 3'd1, 1'b0);
      chk($sformatf("R5 table head step %0d", k), headSlot, TBL[k].expHead);
      chk($sformatf("R9 table count step %0d", k), allocCount, TBL[k].expCnt);
      chk($sformatf("R6 table svc step %0d", k), svcCount, TBL[k].expSvc);
    end
    chk("R1 full at PHYS-RESERVE", full, 1);

    // R3: secure flag must agree
    look(8'd20, 1'b0);
    chk("R3 match hit", matchHit, 1);
    chk("R3 match slot", matchSlot, 1);
    look(8'd20, 1'b1);
    chk("R3 secure mismatch", matchHit, 0);

    // uncacheable entry -> slot 3
    doOp(3'd1, 3'd0, 8'd50, 1'b1, 8'd60, 3'd1, 1'b0);
    look(8'd50, 1'b0);
    chk("R3 uncacheable skipped", matchHit, 0);
    chk("R4 uncacheable pending hit", pendHit, 1);
    chk("R4 pending slot", pendSlot, 3);

    // R6 issue slot 2; R4 excludes in-service, R3 still matches
    doOp(3'd2, 3'd2, 8'd0, 1'b0, 8'd0, 3'd1, 1'b0);
    look(8'd30, 1'b0);
    chk("R4 in-service not pending", pendHit, 0);
    chk("R3 in-service matches", matchHit, 1);
    chk("R6 svc count", svcCount, 1);

    // R8 front on in-service slot: no effect
    doOp(3'd4, 3'd2, 8'd0, 1'b0, 8'd0, 3'd1, 1'b0);
    chk("R8 in-service front ignored", headSlot, 0);

    // alloc slot 4, two targets, earliest time
    doOp(3'd1, 3'd0, 8'd60, 1'b0, 8'd5, 3'd2, 1'b0);
    chk("R5 earliest to head", headSlot, 4);
    chk("R1 all slots live", allocCount, 5);

    // R12 overflow
    doOp(3'd1, 3'd0, 8'd70, 1'b0, 8'd1, 3'd1, 1'b0);
    chk("R12 allocErr pulse", allocErr, 1);
    chk("R12 count unchanged", allocCount, 5);
    chk("R12 head unchanged", headSlot, 4);

    // R11 drain while busy
    @(negedge clk); drainReq = 1'b1;
    @(negedge clk);
    chk("R11 no done while busy", drainDone, 0);

    // R10 pops on slot 4
    doOp(3'd5, 3'd4, 8'd0, 1'b0, 8'd0, 3'd1, 1'b0);
    chk("R10 pop keeps slot", allocCount, 5);
    doOp(3'd5, 3'd4, 8'd0, 1'b0, 8'd0, 3'd1, 1'b0);
    chk("R10 last pop frees", allocCount, 4);
    chk("R10 still full no pulse", popUnfull, 0);
    chk("R10 freed leaves head", headSlot, 0);

    // R6 issue with completion frees slot 1
    doOp(3'd2, 3'd1, 8'd0, 1'b0, 8'd0, 3'd1, 1'b1);
    chk("R6 done-on-issue frees", allocCount, 3);
    chk("R6 svc unchanged", svcCount, 1);

    // R10 pop frees slot 0, full -> not full
    doOp(3'd5, 3'd0, 8'd0, 1'b0, 8'd0, 3'd1, 1'b0);
    chk("R10 popUnfull pulse", popUnfull, 1);
    chk("R1 not full", full, 0);

    // R9 release in-service slot 2
    doOp(3'd6, 3'd2, 8'd0, 1'b0, 8'd0, 3'd1, 1'b0);
    chk("R9 svc decrement", svcCount, 0);
    chk("R9 count decrement", allocCount, 1);

    // R9 / R11 last release
    doOp(3'd6, 3'd3, 8'd0, 1'b0, 8'd0, 3'd1, 1'b0);
    chk("R11 drainDone pulse", drainDone, 1);
    chk("R1 empty", empty, 1);
    chk("R2 LIFO top", allocSlot, 3);
    chk("R5 list empty", headValid, 0);
    @(negedge clk);
    chk("R11 single pulse", drainDone, 0);

    // R11 request while already empty
    drainReq = 1'b0;
    @(negedge clk);
    drainReq = 1'b1;
    @(negedge clk);
    chk("R11 immediate drain", drainDone, 1);
    @(negedge clk);
    chk("R11 immediate single pulse", drainDone, 0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule